// File: doc/BRIEF.md
# Memory Write Cycle Qualifier

This block sits between the three active-low control pins of a parallel memory (chip enable, output enable, write enable) and the command register that sits behind them. It samples the pins on the system clock through a two-stage synchronizer. A stability filter then rejects short noise pulses. Each bus cycle is classified as a read, a write or neither. A qualified write produces exactly one command strobe, at the filtered rising edge of write enable, together with the address and data that were held during the write.

Two lockouts protect the command register. A low-supply indicator, which arrives as a digital input, blocks all writes and clears any write in progress while it is active. A power-up lockout holds the block in read mode after reset. It is released only once the supply has stayed valid for a set number of cycles and a ready input is high. Each time a lockout begins, the block emits a one-cycle command-reset pulse so that the downstream command state can be cleared.

Top module: `wr_cycle_qual`

## Requirements
- R1: A write is qualified only when filtered chip enable is low, write enable is low and output enable is high. When write enable then rises, `cmd_strobe` pulses and `cmd_addr`/`cmd_data` carry the address and data held during the write.
- R2: A write-enable pulse has no effect while chip enable is high or output enable is low: no strobe is produced.
- R3: When all three enables are low, `bus_read` is 1 and `bus_write` is 0 in the following cycle, and the later write-enable rise produces no strobe.
- R4: A level on any control pin that lasts fewer than `FILT_CYCLES` clock samples is ignored. A low pulse of exactly `FILT_CYCLES` samples on write enable is accepted as a write.
- R5: `cmd_strobe` is high for exactly one cycle for each qualified write.
- R6: While the low-supply input is high, `locked` is 1 and no strobe is produced, including for a write that was already in progress. Writes resume without a power-up delay once the input clears.
- R7: After reset `locked` is 1. It falls only after `PWRUP_CYCLES` consecutive cycles with the supply valid and with `ready_in` high. Until then, write pin patterns produce no strobe.
- R8: `cmd_reset` pulses for one cycle when the power-up lockout begins after reset, and again at each rising edge of the low-supply input.
- R9: With every pin inactive after reset, `cmd_strobe`, `cmd_reset` (after its first pulse), `bus_read` and `bus_write` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| addr | input | AW | Bus address |
| data | input | DW | Bus write data |
| vlow | input | 1 | Low-supply indicator, high means supply too low |
| ready_in | input | 1 | Permission to leave power-up lockout |
| cmd_strobe | output | 1 | One-cycle write command strobe |
| cmd_addr | output | AW | Address captured for the strobe |
| cmd_data | output | DW | Data captured for the strobe |
| cmd_reset | output | 1 | One-cycle pulse at each lockout start |
| locked | output | 1 | Writes are currently locked out |
| bus_read | output | 1 | The current filtered cycle is a read |
| bus_write | output | 1 | A qualified write is in progress |

## Verification
The bench builds the block with `FILT_CYCLES` = 3 and `PWRUP_CYCLES` = 20. With these values, a pulse of two samples and one of exactly three samples can both be driven, which places the glitch threshold on both sides of its boundary. They also let the power-up counter saturate in a short run, so the bench can see the lockout held while `ready_in` is low and released once it goes high. Address and data widths of 8 keep the scoreboard items small.

// File: rtl/wcq_pkg.sv
package wcq_pkg;
  typedef enum logic [1:0] {CYC_IDLE = 2'd0, CYC_READ = 2'd1, CYC_WRITE = 2'd2} cyc_t;

  // Pin priority: any cycle with chip and output enable low is a read.
  function automatic cyc_t classify(input logic ce_n, input logic oe_n, input logic we_n);
    if (!ce_n && !oe_n)            return CYC_READ;
    else if (!ce_n && !we_n && oe_n) return CYC_WRITE;
    else                           return CYC_IDLE;
  endfunction

  // Power-up release condition.
  function automatic logic release_ok(input logic cnt_full, input logic ready, input logic low);
    return cnt_full && ready && !low;
  endfunction
endpackage

// File: rtl/wcq_pin_filter.sv
module wcq_pin_filter #(
  parameter int FILT_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  output logic pin_filt
);
  localparam int CW = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1       <= 1'b1;
      s2       <= 1'b1;
      cnt      <= '0;
      pin_filt <= 1'b1;
    end else begin
      s1 <= pin_raw;
      s2 <= s1;
      if (s2 == pin_filt) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        pin_filt <= s2;
        cnt      <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wcq_power_lock.sv
module wcq_power_lock #(
  parameter int PWRUP_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vlow,
  input  logic ready_in,
  output logic lock_any,
  output logic lock_start
);
  import wcq_pkg::*;
  localparam int PW = $clog2(PWRUP_CYCLES + 1);
  localparam logic [PW-1:0] LIM = PW'(PWRUP_CYCLES);

  logic          v1, v2, pu_lock, lock_prev;
  logic [PW-1:0] cnt;
  logic          cnt_full;

  assign cnt_full = (cnt == LIM);
  assign lock_any = pu_lock | v2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1         <= 1'b0;
      v2         <= 1'b0;
      cnt        <= '0;
      pu_lock    <= 1'b1;
      lock_prev  <= 1'b0;
      lock_start <= 1'b0;
    end else begin
      v1 <= vlow;
      v2 <= v1;
      if (v2)             cnt <= '0;
      else if (!cnt_full) cnt <= cnt + 1'b1;
      if (pu_lock && release_ok(cnt_full, ready_in, v2)) pu_lock <= 1'b0;
      lock_prev  <= lock_any;
      lock_start <= lock_any & ~lock_prev;
    end
  end
endmodule

// File: rtl/wcq_cycle_ctrl.sv
module wcq_cycle_ctrl #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_f,
  input  logic          oe_f,
  input  logic          we_f,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          lock_any,
  output logic          cmd_strobe,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic          bus_read,
  output logic          bus_write
);
  import wcq_pkg::*;

  cyc_t          cls;
  logic          we_prev, we_rise, armed;
  logic [AW-1:0] hold_addr;
  logic [DW-1:0] hold_data;

  assign cls       = classify(ce_f, oe_f, we_f);
  assign we_rise   = we_f & ~we_prev;
  assign bus_read  = (cls == CYC_READ);
  assign bus_write = armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_prev    <= 1'b1;
      armed      <= 1'b0;
      cmd_strobe <= 1'b0;
      hold_addr  <= '0;
      hold_data  <= '0;
      cmd_addr   <= '0;
      cmd_data   <= '0;
    end else begin
      we_prev    <= we_f;
      armed      <= (cls == CYC_WRITE) && !lock_any;
      cmd_strobe <= we_rise && armed && !lock_any;
      if (cls == CYC_WRITE) begin
        hold_addr <= addr;
        hold_data <= data;
      end
      if (we_rise && armed && !lock_any) begin
        cmd_addr <= hold_addr;
        cmd_data <= hold_data;
      end
    end
  end
endmodule

// File: rtl/wr_cycle_qual.sv
module wr_cycle_qual #(
  parameter int FILT_CYCLES  = 3,
  parameter int PWRUP_CYCLES = 20,
  parameter int AW           = 8,
  parameter int DW           = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          vlow,
  input  logic          ready_in,
  output logic          cmd_strobe,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic          cmd_reset,
  output logic          locked,
  output logic          bus_read,
  output logic          bus_write
);
  localparam int NPIN = 3;

  logic [NPIN-1:0] pins_raw, pins_filt;
  logic            lock_any, lock_start;

  assign pins_raw = {ce_n, oe_n, we_n};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    wcq_pin_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk(clk), .rst_n(rst_n), .pin_raw(pins_raw[g]), .pin_filt(pins_filt[g])
    );
  end

  wcq_power_lock #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_lock (
    .clk(clk), .rst_n(rst_n), .vlow(vlow), .ready_in(ready_in),
    .lock_any(lock_any), .lock_start(lock_start)
  );

  wcq_cycle_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ce_f(pins_filt[2]), .oe_f(pins_filt[1]), .we_f(pins_filt[0]),
    .addr(addr), .data(data), .lock_any(lock_any),
    .cmd_strobe(cmd_strobe), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .bus_read(bus_read), .bus_write(bus_write)
  );

  assign cmd_reset = lock_start;
  assign locked    = lock_any;
endmodule

// File: rtl/wcq_checker.sv
module wcq_checker (
  input logic clk,
  input logic rst_n,
  input logic cmd_strobe,
  input logic cmd_reset,
  input logic locked,
  input logic bus_read,
  input logic bus_write
);
  // R5
  strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |=> !cmd_strobe);
  // R1
  strobe_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |-> $past(bus_write));
  // R3
  read_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_read |=> !bus_write);
  // R6
  lock_clears_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> !bus_write);
  // R6
  no_strobe_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |-> !$past(locked));
  // R8
  reset_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> !cmd_reset);
  // R8
  reset_with_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |-> $past(locked));
endmodule

bind wr_cycle_qual wcq_checker chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_strobe(cmd_strobe), .cmd_reset(cmd_reset),
  .locked(locked), .bus_read(bus_read), .bus_write(bus_write)
);

// File: tb/wr_cycle_qual_tb_top.sv
module wr_cycle_qual_tb_top;
  localparam int FILT = 3;
  localparam int PWR  = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [7:0] addr = '0, data = '0;
  logic       vlow = 1'b0, ready_in = 1'b0;
  logic       cmd_strobe, cmd_reset, locked, bus_read, bus_write;
  logic [7:0] cmd_addr, cmd_data;

  int checks = 0;
  int errors = 0;
  int resets_seen = 0;
  logic [15:0] exp_q[$];

  always #4 clk = ~clk;

  wr_cycle_qual #(.FILT_CYCLES(FILT), .PWRUP_CYCLES(PWR), .AW(8), .DW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .data(data), .vlow(vlow), .ready_in(ready_in),
    .cmd_strobe(cmd_strobe), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_reset(cmd_reset), .locked(locked), .bus_read(bus_read), .bus_write(bus_write)
  );

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor: each strobe must match the oldest expected write.
  always @(negedge clk) begin
    if (rst_n && cmd_reset) resets_seen++;
    if (rst_n && cmd_strobe) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R1/R2: actual strobe addr %0d expected no strobe", cmd_addr);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        if ({cmd_addr, cmd_data} != e) begin
          errors++;
          $display("FAIL R1: actual %h expected %h", {cmd_addr, cmd_data}, e);
        end
      end
    end
  end

  // Driver: a bus cycle with chosen pin levels and write-enable width.
  task automatic bus_cycle(input logic [7:0] a, input logic [7:0] d, input logic ce,
                           input logic oe, input int we_w, input bit expect_wr);
    addr = a; data = d; ce_n = ce; oe_n = oe;
    cyc(8);
    if (expect_wr) exp_q.push_back({a, d});
    we_n = 1'b0;
    cyc(we_w);
    we_n = 1'b1;
    cyc(10);
    ce_n = 1'b1; oe_n = 1'b1;
    cyc(10);
  endtask

  task automatic drain(input string req);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s: actual %0d pending writes expected 0", req, exp_q.size());
      exp_q.delete();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    // R9 reset state, R7 locked after reset, R8 first pulse
    check("R9 strobe", cmd_strobe, 0);
    check("R9 read", bus_read, 0);
    check("R9 write", bus_write, 0);
    check("R7 locked after reset", locked, 1);
    check("R8 reset pulse count", resets_seen, 1);
    // R7 write during power-up lockout is dropped
    bus_cycle(8'h11, 8'h22, 1'b0, 1'b1, 6, 1'b0);
    cyc(40);
    check("R7 held without ready", locked, 1);
    ready_in = 1'b1;
    cyc(3);
    check("R7 released", locked, 0);
    drain("R7");
    // R1 normal writes with several patterns
    bus_cycle(8'hA5, 8'h3C, 1'b0, 1'b1, 6, 1'b1);
    bus_cycle(8'h00, 8'hFF, 1'b0, 1'b1, 12, 1'b1);
    bus_cycle(8'h7E, 8'h81, 1'b0, 1'b1, 5, 1'b1);
    drain("R1 R5");
    // R2 chip enable high
    bus_cycle(8'h01, 8'h02, 1'b1, 1'b1, 6, 1'b0);
    drain("R2 ce high");
    // R3 all enables low: read
    addr = 8'h44; ce_n = 1'b0; oe_n = 1'b0; cyc(8);
    we_n = 1'b0; cyc(8);
    check("R3 read", bus_read, 1);
    check("R3 no write", bus_write, 0);
    we_n = 1'b1; cyc(10); ce_n = 1'b1; oe_n = 1'b1; cyc(10);
    drain("R3 R2 oe low");
    // R4 glitch rejection and boundary
    bus_cycle(8'h55, 8'h66, 1'b0, 1'b1, FILT - 1, 1'b0);
    drain("R4 short we");
    bus_cycle(8'h57, 8'h68, 1'b0, 1'b1, FILT, 1'b1);
    drain("R4 boundary we");
    oe_n = 1'b1; we_n = 1'b0; cyc(8);
    ce_n = 1'b0; cyc(FILT - 1); ce_n = 1'b1; cyc(8);
    check("R4 ce glitch no write", bus_write, 0);
    we_n = 1'b1; cyc(10);
    drain("R4 ce glitch");
    // R6 low supply
    vlow = 1'b1; cyc(4);
    check("R6 locked", locked, 1);
    check("R8 pulse on low supply", resets_seen, 2);
    bus_cycle(8'h90, 8'h91, 1'b0, 1'b1, 6, 1'b0);
    vlow = 1'b0; cyc(4);
    check("R6 unlocked", locked, 0);
    bus_cycle(8'h92, 8'h93, 1'b0, 1'b1, 6, 1'b1);
    // R6 low supply during a write in progress
    addr = 8'hC0; data = 8'hC1; ce_n = 1'b0; oe_n = 1'b1; cyc(8);
    we_n = 1'b0; cyc(8);
    vlow = 1'b1; cyc(4);
    check("R6 write cleared", bus_write, 0);
    we_n = 1'b1; cyc(10); ce_n = 1'b1; cyc(4);
    vlow = 1'b0; cyc(10);
    check("R8 second low-supply pulse", resets_seen, 3);
    drain("R6");
    cyc(10);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule